// File: doc/BRIEF.md
# Multi-Region Erase Sector Locator

This block turns a byte offset inside a flash array into the erase sector that contains it: the sector's length, its global index and its base address. The array is split into up to four regions placed back to back from offset zero. Each region has its own sector count and its own power-of-two sector length, and the global index runs on from one region into the next. The lookup is purely combinational over registered geometry, so a query gets its answer in the same cycle.

The geometry is taken from the configuration inputs when `cfg_load` is pulsed. It is checked as it is taken, and `config_error` reports a rejected layout. The block also keeps a bitmap with one bit per sector for the sectors queued for erase. A mark port sets the bit of the sector that holds a given offset. A clear port empties the whole map, and the query port reports whether the queried offset lies in a marked sector.

Top module: `sector_locator`

## Requirements
- R1: After reset, `config_error` is 1 and `q_hit` and `q_marked` are 0 until a valid configuration is loaded.
- R2: Region counts are read in order starting at region 0. The first zero count ends the list, and later regions are ignored. If region 0's count is zero, one uniform region built from `cfg_uni_count` and `cfg_uni_size` is used instead, and a zero uniform count is an error.
- R3: For an offset below the total array length, `q_hit`=1, `q_size` is the containing region's sector length, and `q_index` is the number of sectors in earlier regions plus (offset − region base) / sector length. For offsets at or beyond the total length, `q_hit`=0 and `q_index`=0, `q_size`=0, `q_base`=0. The result is valid in the same cycle as `q_off`.
- R4: `q_base` is `q_off` with its low log2(`q_size`) bits cleared.
- R5: A sector length is accepted only if it is a power of two, a multiple of 256 and below 2^24. Any other length in a used region sets `config_error`.
- R6: A used region whose base is not a multiple of its own sector length sets `config_error`.
- R7: `config_error` is set if the total sector count exceeds `NSECT` or the total length exceeds 2^`AW`. Both limits are inclusive.
- R8: While `config_error` is 1, `q_hit`, `q_index`, `q_size`, `q_base` and `q_marked` are all 0.
- R9: A cycle with `mark_en`=1 sets the bit of the sector holding `mark_off`. From the next cycle, `q_marked` is 1 for every offset in that sector. Other sectors are unaffected, and a `mark_off` outside the array marks nothing.
- R10: `clear_all` empties the whole bitmap at the next edge. It wins over a mark in the same cycle.
- R11: `cfg_load` also empties the bitmap. The new geometry and `config_error` apply from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Take and check the configuration inputs |
| cfg_count | input | NREG*CW | Sector count per region, region 0 in the low bits |
| cfg_size | input | NREG*32 | Sector length in bytes per region, region 0 in the low bits |
| cfg_uni_count | input | CW | Sector count of the uniform fallback region |
| cfg_uni_size | input | 32 | Sector length of the uniform fallback region |
| config_error | output | 1 | Loaded geometry was rejected, or nothing is loaded yet |
| q_off | input | AW | Query byte offset |
| q_hit | output | 1 | Query offset lies inside the array |
| q_index | output | log2(NSECT) | Global sector index of the query |
| q_size | output | 32 | Sector length of the query |
| q_base | output | AW | Base address of the queried sector |
| q_marked | output | 1 | Queried sector is queued for erase |
| mark_en | input | 1 | Queue the sector holding `mark_off` |
| mark_off | input | AW | Byte offset to mark |
| clear_all | input | 1 | Empty the erase bitmap |

## Verification
The bench sweeps offsets across whole arrays and uses a fine step around region ends and the array end. Off-by-one bounds there would give a wrong index or a false hit on the first byte past the array. Configurations include regions after a zero count, which a design that did not stop at that count would wrongly map, and layouts sitting exactly at the sector and length limits, which an exclusive limit would reject. Each length and alignment defect is tried alone, so a missing check shows up as a missing `config_error`. Marks are applied inside the array and past its end, and one is applied in the same cycle as a clear, so a wrong priority leaves a stale bit.

// File: rtl/slp_pkg.sv
package slp_pkg;
  localparam int LEN_W  = 32;
  localparam int LG_W   = 5;
  localparam int LEN_LIM_LG = 24;

  // accepted sector length: power of two, multiple of 256, below 2^24
  function automatic logic len_ok(input logic [LEN_W-1:0] l);
    return (l != '0) && ((l & (l - LEN_W'(1))) == '0) &&
           (l[7:0] == 8'h00) && (l[LEN_W-1:LEN_LIM_LG] == '0);
  endfunction

  function automatic logic [LG_W-1:0] len_lg(input logic [LEN_W-1:0] l);
    logic [LG_W-1:0] r;
    r = '0;
    for (int b = 0; b < LEN_W; b++)
      if (l[b]) r = LG_W'(b);
    return r;
  endfunction
endpackage

// File: rtl/slp_cfg_check.sv
module slp_cfg_check
  import slp_pkg::*;
#(
  parameter int NREG  = 4,
  parameter int AW    = 16,
  parameter int CW    = 8,
  parameter int NSECT = 64,
  parameter int IW    = $clog2(NSECT)
) (
  input  logic [NREG*CW-1:0]            cnt_flat,
  input  logic [NREG*LEN_W-1:0]         len_flat,
  input  logic [CW-1:0]                 uni_cnt,
  input  logic [LEN_W-1:0]              uni_len,
  output logic [NREG-1:0]               act,
  output logic [NREG-1:0][LG_W-1:0]     lg,
  output logic [NREG-1:0][AW:0]         base,
  output logic [NREG-1:0][AW:0]         lim,
  output logic [NREG-1:0][IW-1:0]       first,
  output logic                          err
);
  localparam int ACC_W = CW + LEN_W + 4;
  localparam int SC_W  = CW + $clog2(NREG) + 1;

  logic [NREG-1:0][CW-1:0]    ec;
  logic [NREG-1:0][LEN_W-1:0] el;
  logic [ACC_W-1:0]           acc;
  logic [SC_W-1:0]            sacc;
  logic                       run;
  logic                       bad;

  always_comb begin
    for (int i = 0; i < NREG; i++) begin
      ec[i] = cnt_flat[i*CW +: CW];
      el[i] = len_flat[i*LEN_W +: LEN_W];
    end
    if (ec[0] == '0) begin
      for (int i = 1; i < NREG; i++) begin
        ec[i] = '0;
        el[i] = '0;
      end
      ec[0] = uni_cnt;
      el[0] = uni_len;
    end
    run  = 1'b1;
    acc  = '0;
    sacc = '0;
    bad  = 1'b0;
    for (int i = 0; i < NREG; i++) begin
      run      = run & (ec[i] != '0);
      act[i]   = run;
      lg[i]    = len_lg(el[i]);
      base[i]  = acc[AW:0];
      first[i] = sacc[IW-1:0];
      if (run) begin
        if (!len_ok(el[i])) bad = 1'b1;
        if ((acc & (ACC_W'(el[i]) - ACC_W'(1))) != '0) bad = 1'b1;
        acc  = acc + (ACC_W'(ec[i]) << lg[i]);
        sacc = sacc + SC_W'(ec[i]);
      end
      lim[i] = acc[AW:0];
    end
    err = bad | ~act[0] | (acc > (ACC_W'(1) << AW)) | (sacc > SC_W'(NSECT));
  end
endmodule

// File: rtl/slp_lookup.sv
module slp_lookup
  import slp_pkg::*;
#(
  parameter int NREG = 4,
  parameter int AW   = 16,
  parameter int IW   = 6
) (
  input  logic [AW-1:0]             off,
  input  logic [NREG-1:0]           act,
  input  logic [NREG-1:0][LG_W-1:0] lg,
  input  logic [NREG-1:0][AW:0]     base,
  input  logic [NREG-1:0][AW:0]     lim,
  input  logic [NREG-1:0][IW-1:0]   first,
  input  logic                      err,
  output logic                      hit,
  output logic [IW-1:0]             idx,
  output logic [LEN_W-1:0]          size,
  output logic [AW-1:0]             sbase
);
  logic [NREG-1:0]         m;
  logic [NREG-1:0][IW-1:0] ri;
  logic [AW:0]             o1;
  logic [LG_W-1:0]         lgs;

  assign o1 = {1'b0, off};

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [AW:0] rel;
    assign m[g]  = act[g] && (o1 >= base[g]) && (o1 < lim[g]);
    assign rel   = o1 - base[g];
    assign ri[g] = first[g] + IW'(rel >> lg[g]);
  end

  always_comb begin
    hit = (|m) & ~err;
    idx = '0;
    lgs = '0;
    for (int i = 0; i < NREG; i++) begin
      if (m[i]) begin
        idx = idx | ri[i];
        lgs = lgs | lg[i];
      end
    end
    if (!hit) begin
      idx = '0;
      lgs = '0;
    end
    size  = hit ? (LEN_W'(1) << lgs) : '0;
    sbase = hit ? (off & ~((AW'(1) << lgs) - AW'(1))) : '0;
  end
endmodule

// File: rtl/slp_erase_map.sv
module slp_erase_map #(
  parameter int NSECT = 64,
  parameter int IW    = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          set_en,
  input  logic [IW-1:0] set_idx,
  input  logic [IW-1:0] rd_idx,
  output logic          rd_bit
);
  logic [NSECT-1:0] map;

  always_ff @(posedge clk) begin
    if (rst || clr)  map <= '0;
    else if (set_en) map[set_idx] <= 1'b1;
  end

  assign rd_bit = map[rd_idx];
endmodule

// File: rtl/sector_locator.sv
module sector_locator
  import slp_pkg::*;
#(
  parameter int NREG  = 4,
  parameter int AW    = 16,
  parameter int CW    = 8,
  parameter int NSECT = 64
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cfg_load,
  input  logic [NREG*CW-1:0]      cfg_count,
  input  logic [NREG*32-1:0]      cfg_size,
  input  logic [CW-1:0]           cfg_uni_count,
  input  logic [31:0]             cfg_uni_size,
  output logic                    config_error,
  input  logic [AW-1:0]           q_off,
  output logic                    q_hit,
  output logic [$clog2(NSECT)-1:0] q_index,
  output logic [31:0]             q_size,
  output logic [AW-1:0]           q_base,
  output logic                    q_marked,
  input  logic                    mark_en,
  input  logic [AW-1:0]           mark_off,
  input  logic                    clear_all
);
  localparam int IW = $clog2(NSECT);

  logic [NREG-1:0]           n_act,   g_act;
  logic [NREG-1:0][LG_W-1:0] n_lg,    g_lg;
  logic [NREG-1:0][AW:0]     n_base,  g_base;
  logic [NREG-1:0][AW:0]     n_lim,   g_lim;
  logic [NREG-1:0][IW-1:0]   n_first, g_first;
  logic                      n_err,   g_err;

  slp_cfg_check #(.NREG(NREG), .AW(AW), .CW(CW), .NSECT(NSECT), .IW(IW)) u_chk_cfg (
    .cnt_flat(cfg_count), .len_flat(cfg_size),
    .uni_cnt(cfg_uni_count), .uni_len(cfg_uni_size),
    .act(n_act), .lg(n_lg), .base(n_base), .lim(n_lim),
    .first(n_first), .err(n_err)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      g_act   <= '0;
      g_lg    <= '0;
      g_base  <= '0;
      g_lim   <= '0;
      g_first <= '0;
      g_err   <= 1'b1;
    end else if (cfg_load) begin
      g_act   <= n_act;
      g_lg    <= n_lg;
      g_base  <= n_base;
      g_lim   <= n_lim;
      g_first <= n_first;
      g_err   <= n_err;
    end
  end

  assign config_error = g_err;

  logic          m_hit;
  logic [IW-1:0] m_idx;
  logic [31:0]   m_size;
  logic [AW-1:0] m_base;
  logic          rd_bit;

  slp_lookup #(.NREG(NREG), .AW(AW), .IW(IW)) u_qry (
    .off(q_off), .act(g_act), .lg(g_lg), .base(g_base), .lim(g_lim),
    .first(g_first), .err(g_err),
    .hit(q_hit), .idx(q_index), .size(q_size), .sbase(q_base)
  );

  slp_lookup #(.NREG(NREG), .AW(AW), .IW(IW)) u_mrk (
    .off(mark_off), .act(g_act), .lg(g_lg), .base(g_base), .lim(g_lim),
    .first(g_first), .err(g_err),
    .hit(m_hit), .idx(m_idx), .size(m_size), .sbase(m_base)
  );

  slp_erase_map #(.NSECT(NSECT), .IW(IW)) u_map (
    .clk(clk), .rst(rst), .clr(clear_all | cfg_load),
    .set_en(mark_en & m_hit), .set_idx(m_idx),
    .rd_idx(q_index), .rd_bit(rd_bit)
  );

  assign q_marked = q_hit & rd_bit;
endmodule

// File: rtl/sector_locator_chk.sv
module sector_locator_chk #(
  parameter int AW    = 16,
  parameter int NSECT = 64
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     cfg_load,
  input logic                     config_error,
  input logic [AW-1:0]            q_off,
  input logic                     q_hit,
  input logic [$clog2(NSECT)-1:0] q_index,
  input logic [31:0]              q_size,
  input logic [AW-1:0]            q_base,
  input logic                     q_marked,
  input logic                     mark_en,
  input logic [AW-1:0]            mark_off,
  input logic                     clear_all
);
  AST_SIZE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    q_hit |-> ($countones(q_size) == 1 && q_size[7:0] == 8'h00 && q_size < 32'h0100_0000)); // R5

  AST_BASE_ALIGN: assert property (@(posedge clk) disable iff (rst)
    q_hit |-> (((32'(q_base) & (q_size - 32'd1)) == 32'd0) && (q_base <= q_off) &&
               (32'(q_off - q_base) < q_size))); // R4

  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (rst)
    config_error |-> (!q_hit && q_index == '0 && q_size == 32'd0 && q_base == '0 && !q_marked)); // R8

  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    (clear_all || cfg_load) |=> !q_marked); // R10

  AST_MARK_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (mark_en && !clear_all && !cfg_load && !config_error && q_hit && mark_off == q_off)
      ##1 $stable(q_off) |-> q_marked); // R9
endmodule

bind sector_locator sector_locator_chk #(.AW(AW), .NSECT(NSECT)) u_chk (
  .clk(clk), .rst(rst), .cfg_load(cfg_load), .config_error(config_error),
  .q_off(q_off), .q_hit(q_hit), .q_index(q_index), .q_size(q_size),
  .q_base(q_base), .q_marked(q_marked), .mark_en(mark_en),
  .mark_off(mark_off), .clear_all(clear_all)
);

// File: tb/sector_locator_tb.sv
`timescale 1ns/1ps
module sector_locator_tb;
  localparam int AW = 16, CW = 8, NSECT = 64, NREG = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic cfg_load = 1'b0;
  logic [NREG*CW-1:0] cfg_count = '0;
  logic [NREG*32-1:0] cfg_size = '0;
  logic [CW-1:0] cfg_uni_count = '0;
  logic [31:0] cfg_uni_size = '0;
  logic config_error;
  logic [AW-1:0] q_off = '0;
  logic q_hit;
  logic [5:0] q_index;
  logic [31:0] q_size;
  logic [AW-1:0] q_base;
  logic q_marked;
  logic mark_en = 1'b0;
  logic [AW-1:0] mark_off = '0;
  logic clear_all = 1'b0;

  sector_locator #(.NREG(NREG), .AW(AW), .CW(CW), .NSECT(NSECT)) u_dut (.*);

  always #2 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  int em_c[4], em_l[4];
  bit [63:0] exp_map = '0;

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic model(input int off, output bit hit, output int idx, output int len);
    int b = 0, f = 0;
    hit = 0; idx = 0; len = 0;
    for (int i = 0; i < 4; i++) begin
      if (em_c[i] == 0) break;
      if (!hit && off >= b && off < b + em_c[i] * em_l[i]) begin
        hit = 1; idx = f + (off - b) / em_l[i]; len = em_l[i];
      end
      b += em_c[i] * em_l[i];
      f += em_c[i];
    end
  endtask

  task automatic apply_cfg(input int c0, c1, c2, c3, l0, l1, l2, l3, uc, ul,
                           input bit exp_err, input string req);
    cfg_count = {8'(c3), 8'(c2), 8'(c1), 8'(c0)};
    cfg_size  = {32'(l3), 32'(l2), 32'(l1), 32'(l0)};
    cfg_uni_count = 8'(uc);
    cfg_uni_size  = 32'(ul);
    cfg_load = 1'b1;
    tick();
    cfg_load = 1'b0;
    chk(req, "config_error", config_error, exp_err);
    if (c0 == 0) begin
      em_c = '{uc, 0, 0, 0}; em_l = '{ul, 0, 0, 0};
    end else begin
      em_c = '{c0, c1, c2, c3}; em_l = '{l0, l1, l2, l3};
    end
    exp_map = '0;
  endtask

  task automatic sweep(input int lo, input int hi, input int step);
    bit h; int ix, ln;
    for (int off = lo; off <= hi && off < 65536; off += step) begin
      q_off = 16'(off);
      #1;
      model(off, h, ix, ln);
      chk("R3", "hit", q_hit, h);
      chk("R3", "index", q_index, h ? ix : 0);
      chk("R3", "size", q_size, ln);
      chk("R4", "base", q_base, h ? (off & ~(ln - 1)) : 0);
      chk("R9", "marked", q_marked, h ? exp_map[ix] : 1'b0);
    end
  endtask

  task automatic do_mark(input int off);
    bit h; int ix, ln;
    mark_off = 16'(off);
    mark_en = 1'b1;
    tick();
    mark_en = 1'b0;
    model(off, h, ix, ln);
    if (h) exp_map[ix] = 1'b1;
  endtask

  task automatic err_quiet();
    for (int k = 0; k < 3; k++) begin
      q_off = 16'(k * 16'h0500);
      #1;
      chk("R8", "quiet outputs", {q_hit, q_marked, q_index, q_size, q_base}, 0);
    end
  endtask

  initial begin
    repeat (3) tick();
    q_off = '0;
    #1;
    chk("R1", "config_error at reset", config_error, 1);
    chk("R1", "hit at reset", q_hit, 0);
    chk("R1", "marked at reset", q_marked, 0);
    rst = 1'b0;
    tick();
    chk("R1", "config_error before load", config_error, 1);

    // three regions, fourth unused
    apply_cfg(4, 8, 2, 0, 'h400, 'h1000, 'h100, 'h100, 0, 0, 0, "R2");
    sweep(0, 65535, 'h40);
    sweep('h8FF0, 'h9210, 1);
    do_mark('h0400); do_mark('h5000); do_mark('h9100); do_mark('h9800);
    sweep(0, 'h9400, 'h40);
    // clear wins over a mark in the same cycle (R10)
    mark_off = 16'h0000; mark_en = 1'b1; clear_all = 1'b1;
    tick();
    mark_en = 1'b0; clear_all = 1'b0;
    exp_map = '0;
    sweep(0, 'h9400, 'h100);
    // reload empties the map (R11)
    do_mark('h2000);
    sweep('h1000, 'h3000, 'h100);
    apply_cfg(4, 8, 2, 0, 'h400, 'h1000, 'h100, 'h100, 0, 0, 0, "R11");
    sweep(0, 'h9400, 'h100);

    // zero count ends the list (R2)
    apply_cfg(4, 0, 9, 9, 'h400, 'h1000, 'h100, 'h100, 0, 0, 0, "R2");
    sweep(0, 'h3000, 'h80);
    // uniform fallback (R2)
    apply_cfg(0, 5, 5, 5, 'h400, 'h400, 'h400, 'h400, 16, 'h1000, 0, "R2");
    sweep(0, 65535, 'h80);
    apply_cfg(0, 5, 5, 5, 'h400, 'h400, 'h400, 'h400, 0, 'h1000, 1, "R2");
    err_quiet();
    // four regions, full space
    apply_cfg(2, 4, 8, 1, 'h2000, 'h800, 'h400, 'h8000, 0, 0, 0, "R3");
    sweep(0, 65535, 'h40);
    sweep('h3FF0, 'h4010, 1);
    // exact limits accepted (R7)
    apply_cfg(0, 0, 0, 0, 0, 0, 0, 0, 64, 'h400, 0, "R7");
    sweep(0, 65535, 'h100);
    sweep('hFFF0, 'hFFFF, 1);

    // rejected layouts
    apply_cfg(2, 0, 0, 0, 'h180, 0, 0, 0, 0, 0, 1, "R5"); err_quiet();
    apply_cfg(2, 0, 0, 0, 'h80, 0, 0, 0, 0, 0, 1, "R5"); err_quiet();
    apply_cfg(0, 0, 0, 0, 0, 0, 0, 0, 1, 'h100_0000, 1, "R5"); err_quiet();
    apply_cfg(1, 1, 0, 0, 'h100, 'h1000, 0, 0, 0, 0, 1, "R6"); err_quiet();
    apply_cfg(0, 0, 0, 0, 0, 0, 0, 0, 65, 'h100, 1, "R7"); err_quiet();
    apply_cfg(2, 0, 0, 0, 'h10000, 0, 0, 0, 0, 0, 1, "R7"); err_quiet();
    do_mark('h0000);
    err_quiet();

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule